// File: doc/BRIEF.md
# UART Transmit Staging Buffer

This block holds the bytes a high-speed UART is about to send. A host writes bytes into a memory window. Each byte lands at the current write pointer plus its offset inside the window, wrapping around the end of the buffer. Writing to the window does not release anything to the transmitter. The bytes stay staged until the host writes a byte count to the control register. That commit moves the write pointer forward by the count and adds the count to the number of bytes waiting to go out. Because of this, a host can copy a message in unaligned pieces and release it all at once.

The serializer pulls bytes from a simple pop port. It sees a valid flag and the byte at the head of the queue, and each pop consumes one committed byte. The host can read the write pointer and the pending count from the control register. An empty flag tells the rest of the UART when every committed byte has been taken. The serializer itself is not part of this block.

Top module: `uart_tx_stage`

## Requirements
- R1: After reset, the write pointer and the pending count are both zero, `txEmpty` is 1 and `txValid` is 0.
- R2: A word write to window byte address `0x400 + 4*j` stores lane k (data bits [8k+7:8k]) at buffer position `(wptr + 4*j + k) mod 1024`. The window covers byte addresses 0x400 to 0x7FF, and only aligned word writes (address bits [1:0] = 0) are accepted.
- R3: A window write does not change the write pointer, the pending count, `txValid` or `txEmpty`.
- R4: A write of N to the control register (byte address 0x804, count in data bits [9:0]) adds N to the pending count and advances the write pointer by N modulo 1024, when N is within the free space.
- R5: A read of address 0x804 returns, on the clock edge after `hostRdEn` is sampled, the write pointer in bits [9:0] and the pending count in bits [25:16], with every other bit 0. The value is taken before any update made on that same edge.
- R6: Each pop (`txPop` high while `txValid` is 1) hands out committed bytes in buffer order starting at position 0 after reset, and lowers the pending count by one. A pop while nothing is pending is ignored.
- R7: `txEmpty` is 1 exactly when the pending count is zero, and `txValid` is its inverse.
- R8: The pending count never exceeds 1020. A commit larger than `1020 - pending` is cut to that free space, and the write pointer advances by the reduced amount only.
- R9: When a commit and a pop happen on the same edge, the new count is `pending + committed - 1`. The free space used for the clamp is computed from the count before the pop.
- R10: Window bytes whose `hostByteEn` bit is 0 leave the buffer entry at their position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 12 | Host byte address |
| hostWrData | input | 32 | Host write data |
| hostByteEn | input | 4 | Per-byte write enables for window writes |
| hostRdData | output | 32 | Registered read data |
| txPop | input | 1 | Serializer takes the head byte |
| txData | output | 8 | Byte at the head of the committed queue |
| txValid | output | 1 | At least one committed byte is waiting |
| txEmpty | output | 1 | No committed byte is waiting |

## Verification
The bench targets the following corner cases, and for each one states how a faulty design would show up:

- **Staged writes:** the bench writes to the window with no commit after it. A design that published staged bytes early would raise `txValid` or move the counters.
- **Wrap at the end of the buffer:** the bench places the write pointer at 1016 and copies and sends twelve bytes across the wrap. A design that lost the modulo on the lane offset, the write pointer or the read pointer would send bytes out of order.
- **Oversized commits:** the bench commits more than the free space, once from empty and once with a pop on the same edge. A design that skipped the clamp, or computed the free space after the pop, would report a count above 1020 or a wrong write pointer.
- **Disabled byte lanes:** a masked overwrite must leave the lanes that are switched off unchanged. A design that ignored the enables would send the new bytes instead of the old ones.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int PTR_W      = 10;
  localparam int DEPTH      = 1 << PTR_W;
  localparam int COMMIT_CAP = 1020;
  localparam int LANES      = 4;
  localparam int LANE_W     = $clog2(LANES);
  localparam int BYTE_W     = 8;

  typedef logic [PTR_W-1:0] ptr_t;

  // Write strobes handed from control to the byte store.
  typedef struct packed {
    logic [LANES-1:0]              laneWe;
    logic [LANES-1:0][PTR_W-1:0]   laneAddr;
    logic [LANES-1:0][BYTE_W-1:0]  laneData;
  } bufStrobe_t;
endpackage

// File: rtl/txbuf_store.sv
module txbuf_store
  import txbuf_pkg::*;
(
  input  logic              clk,
  input  bufStrobe_t        strobe,
  input  ptr_t              rdPtr,
  output logic [BYTE_W-1:0] rdByte
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // Lane positions are consecutive modulo DEPTH, so they never collide.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (strobe.laneWe[k]) mem[strobe.laneAddr[k]] <= strobe.laneData[k];
    end
  end

  assign rdByte = mem[rdPtr];
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WIN_BASE = 'h400,
  parameter int CTRL_OFF = 'h804
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [LANES-1:0]  hostByteEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              txPop,
  output logic              txValid,
  output logic              txEmpty,
  output bufStrobe_t        strobe,
  output ptr_t              rdPtr
);
  localparam int WIN_TAG    = WIN_BASE >> PTR_W;
  localparam int CNT_SHIFT  = 16;
  localparam int HI_PAD     = DATA_W - CNT_SHIFT - PTR_W;
  localparam int MID_PAD    = CNT_SHIFT - PTR_W;
  localparam int WORD_BITS  = PTR_W - LANE_W;

  ptr_t wrPtr, pending, commitReq, freeSpace, commitAmt;
  logic winHit, ctrlHit, winWrite, commitWr, popFire;
  logic [WORD_BITS-1:0] wordIdx;

  // Decode.
  assign winHit   = (hostAddr[ADDR_W-1:PTR_W] == (ADDR_W-PTR_W)'(WIN_TAG))
                  && (hostAddr[LANE_W-1:0] == '0);
  assign ctrlHit  = (hostAddr == ADDR_W'(CTRL_OFF));
  assign winWrite = hostWrEn && winHit;
  assign commitWr = hostWrEn && ctrlHit;
  assign wordIdx  = hostAddr[PTR_W-1:LANE_W];

  // Window lane strobes: lane k lands at wrPtr + window offset + k.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      strobe.laneWe[k]   = winWrite && hostByteEn[k];
      strobe.laneAddr[k] = wrPtr + ptr_t'({wordIdx, LANE_W'(k)});
      strobe.laneData[k] = hostWrData[k*BYTE_W +: BYTE_W];
    end
  end

  // Commit with clamp against space left before the cap.
  assign commitReq = hostWrData[PTR_W-1:0];
  assign freeSpace = ptr_t'(COMMIT_CAP) - pending;
  assign commitAmt = commitWr ? ((commitReq > freeSpace) ? freeSpace : commitReq) : '0;
  assign txEmpty   = (pending == '0);
  assign txValid   = !txEmpty;
  assign popFire   = txPop && txValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      pending <= '0;
    end else begin
      wrPtr   <= wrPtr + commitAmt;
      pending <= pending + commitAmt - ptr_t'(popFire);
      if (popFire) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else if (hostRdEn) begin
      hostRdData <= ctrlHit ? {HI_PAD'(0), pending, MID_PAD'(0), wrPtr} : '0;
    end
  end

  // R8: count stays within the cap.
  a_r8_cap_bound: assert property (@(posedge clk) disable iff (!rstN)
    pending <= ptr_t'(COMMIT_CAP));

  // R3: staged window writes do not publish anything.
  a_r3_stage_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (winWrite && !popFire) |=> ($stable(wrPtr) && $stable(pending)));

  // R4: an in-range commit moves the pointer by the requested count.
  a_r4_commit_step: assert property (@(posedge clk) disable iff (!rstN)
    (commitWr && !popFire && (commitReq <= freeSpace))
      |=> (wrPtr == ptr_t'($past(wrPtr) + $past(commitReq))));

  // R6: a lone pop steps the read pointer and the count by one.
  a_r6_pop_step: assert property (@(posedge clk) disable iff (!rstN)
    (popFire && !commitWr)
      |=> ((pending == ptr_t'($past(pending) - 1'b1)) && (rdPtr == ptr_t'($past(rdPtr) + 1'b1))));

  // R6: nothing pending and nothing committed leaves the read side still.
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !commitWr) |=> ($stable(rdPtr) && txEmpty));
endmodule

// File: rtl/uart_tx_stage.sv
module uart_tx_stage
  import txbuf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WIN_BASE = 'h400,
  parameter int CTRL_OFF = 'h804
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [3:0]        hostByteEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              txPop,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txEmpty
);
  bufStrobe_t strobe;
  ptr_t       rdPtr;

  txbuf_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .CTRL_OFF(CTRL_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostByteEn(hostByteEn),
    .hostRdData(hostRdData), .txPop(txPop), .txValid(txValid), .txEmpty(txEmpty),
    .strobe(strobe), .rdPtr(rdPtr)
  );

  txbuf_store u_store (
    .clk(clk), .strobe(strobe), .rdPtr(rdPtr), .rdByte(txData)
  );
endmodule

// File: tb/tb_uart_tx_stage.sv
module tb_uart_tx_stage;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int CAP   = 1020;

  logic clk = 0, rstN = 0;
  logic hostWrEn = 0, hostRdEn = 0, txPop = 0;
  logic [11:0] hostAddr = 0;
  logic [31:0] hostWrData = 0, hostRdData;
  logic [3:0] hostByteEn = 0;
  logic [7:0] txData;
  logic txValid, txEmpty;

  int nChecks = 0, nFails = 0;
  logic [7:0] refMem [DEPTH];
  int refW = 0, refP = 0, refR = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_stage dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostByteEn(hostByteEn),
    .hostRdData(hostRdData), .txPop(txPop), .txData(txData),
    .txValid(txValid), .txEmpty(txEmpty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic winWrite(input int off, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    hostWrEn = 1; hostAddr = 12'(32'h400 + off); hostWrData = d; hostByteEn = be;
    @(negedge clk);
    hostWrEn = 0; hostByteEn = 0;
    for (int k = 0; k < 4; k++)
      if (be[k]) refMem[(refW + off + k) % DEPTH] = d[k*8 +: 8];
  endtask

  function automatic int clampAmt(input int n);
    return (n > CAP - refP) ? CAP - refP : n;
  endfunction

  task automatic commit(input int n);
    int c;
    c = clampAmt(n);
    @(negedge clk);
    hostWrEn = 1; hostAddr = 12'h804; hostWrData = 32'(n);
    @(negedge clk);
    hostWrEn = 0;
    refW = (refW + c) % DEPTH; refP += c;
  endtask

  task automatic readCtrl(input string req);
    @(negedge clk);
    hostRdEn = 1; hostAddr = 12'h804;
    @(negedge clk);
    hostRdEn = 0;
    chk(req, hostRdData, {6'b0, 10'(refP), 6'b0, 10'(refW)});
    chk(req, {30'b0, txEmpty, txValid}, {30'b0, refP == 0, refP != 0});
  endtask

  task automatic popCheck(input string req);
    @(negedge clk);
    chk(req, {31'b0, txValid}, 1);
    chk(req, {24'b0, txData}, {24'b0, refMem[refR]});
    txPop = 1;
    @(negedge clk);
    txPop = 0;
    refR = (refR + 1) % DEPTH; refP--;
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    txPop = 1;
    repeat (n) @(negedge clk);
    txPop = 0;
    refR = (refR + n) % DEPTH; refP -= n;
  endtask

  // Commit and pop on the same edge.
  task automatic commitWithPop(input int n, input bit checkData, input string req);
    int c;
    c = clampAmt(n);
    @(negedge clk);
    if (checkData) chk(req, {24'b0, txData}, {24'b0, refMem[refR]});
    hostWrEn = 1; hostAddr = 12'h804; hostWrData = 32'(n); txPop = 1;
    @(negedge clk);
    hostWrEn = 0; txPop = 0;
    refW = (refW + c) % DEPTH; refP = refP + c - 1; refR = (refR + 1) % DEPTH;
  endtask

  task automatic testReset();
    readCtrl("R1 reset state");
    chk("R7 empty after reset", {31'b0, txEmpty}, 1);
  endtask

  task automatic testStaging();
    winWrite(0, 32'h44332211, 4'hF);
    winWrite(4, 32'h88776655, 4'hF);
    readCtrl("R3 staged writes invisible");
    chk("R3 no valid while staged", {31'b0, txValid}, 0);
  endtask

  task automatic testCommitPop();
    commit(6);
    readCtrl("R4 R5 commit advances");
    for (int i = 0; i < 6; i++) popCheck("R6 R2 in-order pop");
    readCtrl("R7 empty after drain");
    @(negedge clk); txPop = 1;
    @(negedge clk); txPop = 0;
    readCtrl("R6 pop while empty ignored");
  endtask

  task automatic testMask();
    winWrite(0, 32'hAABBCCDD, 4'hF);
    winWrite(0, 32'h11223344, 4'b0101);
    commit(4);
    readCtrl("R4 unaligned commit");
    for (int i = 0; i < 4; i++) popCheck("R10 disabled lanes keep data");
  endtask

  task automatic testClamp();
    commit(1023);
    readCtrl("R8 oversize commit clamped");
    commit(5);
    readCtrl("R8 commit at cap adds nothing");
    drain(CAP);
    readCtrl("R8 drained after cap");
  endtask

  task automatic testWrap();
    commit(1010);
    drain(1010);
    readCtrl("R4 pointer at 1016");
    winWrite(0, 32'h03020100, 4'hF);
    winWrite(4, 32'h07060504, 4'hF);
    winWrite(8, 32'h0B0A0908, 4'hF);
    commit(12);
    readCtrl("R4 pointer wraps");
    for (int i = 0; i < 12; i++) popCheck("R2 R6 bytes across wrap");
  endtask

  task automatic testConcurrent();
    winWrite(0, 32'hD4C3B2A1, 4'hF);
    commit(3);
    commitWithPop(2, 1'b1, "R9 head byte during joint cycle");
    readCtrl("R9 commit plus pop");
    for (int i = 0; i < 4; i++) popCheck("R9 order after joint cycle");
    commit(1019);
    commitWithPop(5, 1'b0, "R9 clamp before pop");
    readCtrl("R9 clamp uses pre-pop count");
    drain(refP);
    readCtrl("R7 final empty");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testStaging();
    testCommitPop();
    testMask();
    testClamp();
    testWrap();
    testConcurrent();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule